// File: doc/BRIEF.md
# Overlapping Serial 1011 Recognizer

This block watches a one-bit serial stream and raises a one-bit flag in the same cycle that the final bit of the pattern 1, 0, 1, 1 arrives, with the bits taken in arrival order. The design is a Mealy machine. The flag depends on the registered partial-match state and on the bit being presented now, so the flag appears without waiting for a clock edge.

Matches may overlap. After a hit, the closing 1 becomes the first bit of the next candidate. A partial 101 that is followed by 0 keeps its trailing 10. A synchronous, active-high reset discards any partial match and holds the flag low while reset is asserted.

Top module: `patrec_1011`

## Requirements
- R1: The output y is 1 in a cycle when x is 1 and the three bits accepted at the previous three rising edges since reset were, oldest first, 1, 0, 1.
- R2: The output y is 0 in every cycle in which the condition of R1 does not hold, including the first three bits after reset.
- R3: Matches overlap: the stream 1011011 (starting from reset) gives y = 1 on its 4th and 7th bits only.
- R4: After a partial 101, a 0 keeps the trailing 10, so the stream 101011 gives y = 1 on its 6th bit only.
- R5: While rst is 1, y is 0 whatever x is. A rising edge with rst = 1 clears any partial match, so none of the bits accepted before that edge contribute to a later detection.
- R6: For the stream 1110010010011011010110111111 fed from reset, y is 1 exactly at bit positions 16, 21 and 24, counting from 1.
- R7: A run of consecutive 1s keeps a single-1 partial match, so 1111011 gives y = 1 on its 7th bit only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; x is accepted on each edge |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 1 | Serial data bit |
| y | output | 1 | Detection flag, combinational from state and x |

## Verification
Reset and a completing detection can fall in the same cycle. This happens when rst rises while the machine holds a partial 101 and x is 1. The bench provokes this case on purpose. It requires y to stay 0 in that cycle. It then feeds two more 1s after reset and requires no detection, which shows that the old 101 was really discarded. Random streams that are dense in 1s, and streams with more 0s, are compared against a bench shift-register model. Reset pulses are injected in the middle of the streams.

// File: rtl/patrec_pkg.sv
package patrec_pkg;
    localparam int STATE_COUNT = 4;
    localparam int STATE_W     = $clog2(STATE_COUNT);

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'd0,
        ST_GOT1   = 2'd1,
        ST_GOT10  = 2'd2,
        ST_GOT101 = 2'd3
    } pr_state_e;

    typedef struct packed {
        pr_state_e state;
        logic      hit;
    } pr_step_t;
endpackage

// File: rtl/patrec_step.sv
module patrec_step
    import patrec_pkg::*;
(
    input  pr_state_e cur,
    input  logic      bit_in,
    output pr_step_t  step
);
    always_comb begin
        step.hit   = 1'b0;
        step.state = ST_IDLE;
        unique case (cur)
            ST_IDLE:   step.state = bit_in ? ST_GOT1 : ST_IDLE;
            ST_GOT1:   step.state = bit_in ? ST_GOT1 : ST_GOT10;
            ST_GOT10:  step.state = bit_in ? ST_GOT101 : ST_IDLE;
            ST_GOT101: begin
                // closing 1 restarts at single-1, a 0 keeps trailing 10
                step.state = bit_in ? ST_GOT1 : ST_GOT10;
                step.hit   = bit_in;
            end
            default:   step.state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/patrec_1011.sv
module patrec_1011
    import patrec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output logic y
);
    pr_state_e state_q;
    pr_step_t  raw_step;
    pr_step_t  step_d;

    patrec_step u_step (
        .cur    (state_q),
        .bit_in (x),
        .step   (raw_step)
    );

    always_comb begin
        step_d = raw_step;
        if (rst) begin
            step_d.state = ST_IDLE;
            step_d.hit   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= step_d.state;
    end

    assign y = step_d.hit;

    // R5
    reset_quiet_chk: assert property (@(posedge clk) rst |-> !y);

    // R5
    reset_clears_chk: assert property (@(posedge clk) rst |=> state_q == ST_IDLE);

    // R2
    no_false_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_GOT101) |-> !y);

    // R1
    hit_history_chk: assert property (@(posedge clk) disable iff (rst)
        y |-> ($past(x, 1) && !$past(x, 2) && $past(x, 3)));

    // R3
    overlap_restart_chk: assert property (@(posedge clk) disable iff (rst)
        y |=> state_q == ST_GOT1);
endmodule

// File: tb/patrec_1011_test.sv
module patrec_1011_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic y;

    int checks = 0;
    int fails  = 0;
    logic [2:0] hist = 3'b000;
    int nvalid = 0;
    int pos = 0;

    patrec_1011 uut (.clk(clk), .rst(rst), .x(x), .y(y));

    always #10 clk = ~clk;

    function automatic logic model_y(logic [2:0] h, int n, logic b);
        return (n >= 3) && ({h, b} == 4'b1011);
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", req, pos, act, exp);
        end
    endtask

    task automatic push(logic b, string req, int use_lit, logic lit);
        @(negedge clk);
        rst = 1'b0;
        x = b;
        pos++;
        #2;
        check(req, y, use_lit != 0 ? lit : model_y(hist, nvalid, b));
        hist = {hist[1:0], b};
        nvalid++;
    endtask

    task automatic do_reset(logic b);
        @(negedge clk);
        rst = 1'b1;
        x = b;
        #2;
        check("R5", y, 1'b0);
        hist = 3'b000;
        nvalid = 0;
        pos = 0;
    endtask

    task automatic push_str(string s, string req, int p1, int p2, int p3);
        for (int i = 0; i < s.len(); i++) begin
            logic b;
            b = (s[i] == "1");
            push(b, req, 1, ((i+1) == p1) || ((i+1) == p2) || ((i+1) == p3));
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b1);
        do_reset(1'b0);
        // R2 reset state: first bits give no detection
        push_str("101", "R2", 0, 0, 0);
        do_reset(1'b0);
        push_str("1011011", "R3", 4, 7, 0);
        do_reset(1'b0);
        push_str("101011", "R4", 6, 0, 0);
        do_reset(1'b0);
        push_str("1111011", "R7", 7, 0, 0);
        do_reset(1'b0);
        push_str("1110010010011011010110111111", "R6", 16, 21, 24);
        // R5: reset collides with a completing detection
        do_reset(1'b0);
        push_str("101", "R5", 0, 0, 0);
        do_reset(1'b1);
        push_str("11", "R5", 0, 0, 0);
        // R1 and R2 against model: random streams
        do_reset(1'b0);
        for (int i = 0; i < 3000; i++) begin
            logic b;
            if (i % 400 == 399) do_reset(1'b1);
            if (i < 1500) b = ($urandom % 4) != 0;
            else          b = ($urandom % 3) == 0;
            push(b, "R1", 0, 1'b0);
        end
        finish_up();
    end
endmodule